// File: doc/BRIEF.md
# Packet-Command PIO Read Controller

This block is the device side of a packet-command read in programmed-I/O mode, seen by the host through a small task-file register window. The host writes a transfer byte-count limit into two byte-wide registers, clears the DMA-select feature bit and issues the packet command. The controller briefly shows busy, then asks for the 12-byte command packet, which the host supplies as six 16-bit writes to the data register.

Once the packet is complete, the controller decodes a READ(10) request. It range-checks the request against the media size and streams the requested 2048-byte blocks out of a simple block-read port. The data leaves in bursts, and each burst is sized by the host's byte-count limit. Before every burst the controller raises its interrupt and reloads the byte-count registers with the size of that burst. A status read clears the interrupt, and the host then reads that many bytes as 16-bit words. A final interrupt marks completion. A request that cannot be served ends at once with an error and an abort indication.

Top module: `atapi_pio_ctrl`

## Requirements
- R1: After reset, status (register index 7) reads 0x40, with only the ready bit (bit 6) set. The error register (index 1) reads 0 and `irq` is low.
- R2: Writing command code 0xA0 to index 7 in idle, with feature (index 1) bit 0 clear, shows busy (status bit 7) and then status 0x48 (ready plus data-request bit 3). The controller then takes six data-register (index 0) writes as the packet. Each write carries packet byte 2i in bits 7:0 and byte 2i+1 in bits 15:8.
- R3: A packet with opcode 0x28 in byte 0 names a starting block in bytes 2..5 and a block count in bytes 7..8, both most significant byte first. Each data-register read in the transfer returns the source word at the current block and word index (1024 words per block). The index advances sequentially and carries into the next block.
- R4: The byte-count limit is index 4 (low byte) and index 5 (high byte), captured when the command is accepted. Each burst is the remaining byte count if that is below the limit, and otherwise the limit with bit 0 cleared. At the start of a burst, indices 4 and 5 read back that burst size.
- R5: `irq` rises before each burst while status reads 0x48. A status read clears `irq`.
- R6: After the last word of a burst that is not the final one, data request drops and status reads 0xC0 (busy plus ready) until the next burst starts.
- R7: After the final word, `irq` rises again and status reads 0x40.
- R8: A packet command issued while feature bit 0 is set is refused. Status becomes 0x41 (error bit 0), the error register becomes 0x04 (abort bit 2), `irq` rises and no data request appears.
- R9: An opcode other than 0x28, or a start block plus count above MEDIA_BLOCKS, ends the command with status 0x41, error register 0x04 and `irq`, with no data phase.
- R10: A block count of zero completes with `irq`, status 0x40 and error register 0.
- R11: A captured limit of 0 or 1 is treated as 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Task-file register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| blk_lba | output | 32 | Block address presented to the data source |
| blk_word | output | 10 | Word index within the block |
| blk_data | input | 16 | Source word for `blk_lba`/`blk_word` |

## Verification
The hardest case to reach is a burst boundary that falls inside a block, combined with a transfer that also crosses into the next block. The word index then keeps running across a burst pause, and the last burst is a short remainder. The bench gets there with an odd limit of 1001 on a two-block read that starts at the last valid pair of blocks. This gives four 1000-byte bursts and a 96-byte tail, and the data model tracks the expected block and word on its own. Other odd limits, one above and one below the transfer size, exercise both branches of the sizing rule.

// File: rtl/atapi_pio_ctrl.sv
module atapi_pio_ctrl #(
  parameter int MEDIA_BLOCKS = 64,
  parameter logic [7:0] PACKET_OP = 8'hA0,
  parameter logic [7:0] READ10_OP = 8'h28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic [31:0] blk_lba,
  output logic [9:0]  blk_word,
  input  logic [15:0] blk_data
);
  localparam int BLK_SHIFT = 11;
  localparam int REM_W = 16 + BLK_SHIFT;

  typedef enum logic [2:0] {S_IDLE, S_ACC, S_PKT, S_DEC, S_XFER, S_GAP} st_t;
  st_t st;

  logic [15:0] bcnt, lim;
  logic feat0, abrt;
  logic [95:0] pkt;
  logic [2:0] pkt_n;
  logic [REM_W-1:0] rem;
  logic [14:0] wleft;
  logic [31:0] cur_lba;
  logic [9:0] cur_w;

  wire wr_cmd  = reg_wr && reg_addr == 3'd7;
  wire wr_dat  = reg_wr && reg_addr == 3'd0;
  wire rd_stat = reg_rd && reg_addr == 3'd7;
  wire rd_dat  = reg_rd && reg_addr == 3'd0 && st == S_XFER;
  wire is_pkt  = wr_cmd && st == S_IDLE && reg_wdata[7:0] == PACKET_OP;

  wire [15:0] lim_eff = (lim < 16'd2) ? 16'hFFFE : lim;
  wire [15:0] burst = (rem < REM_W'(lim_eff)) ? rem[15:0] : {lim_eff[15:1], 1'b0};

  wire [7:0]  c_op  = pkt[95:88];
  wire [31:0] c_lba = pkt[79:48];
  wire [15:0] c_cnt = pkt[39:24];
  wire [32:0] c_end = {1'b0, c_lba} + 33'(c_cnt);
  wire c_bad = (c_op != READ10_OP) || (c_end > 33'(MEDIA_BLOCKS));
  wire last_word = rd_dat && wleft == 15'd1;
  wire fin_word = last_word && rem == REM_W'(2);

  wire irq_set = (is_pkt && feat0) || (st == S_DEC && (c_bad || c_cnt == 16'd0)) ||
                 (st == S_GAP) || fin_word;

  wire bsy = (st == S_ACC) || (st == S_DEC) || (st == S_GAP);
  wire drq = (st == S_PKT) || (st == S_XFER);
  wire [7:0] status = {bsy, 1'b1, 1'b0, 1'b0, drq, 2'b00, abrt};

  assign blk_lba = cur_lba;
  assign blk_word = cur_w;

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = (st == S_XFER) ? blk_data : 16'h0;
      3'd1: reg_rdata = {13'd0, abrt, 2'b00};
      3'd4: reg_rdata = {8'd0, bcnt[7:0]};
      3'd5: reg_rdata = {8'd0, bcnt[15:8]};
      3'd7: reg_rdata = {8'd0, status};
      default: reg_rdata = 16'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; lim <= '0; feat0 <= 1'b0; abrt <= 1'b0;
      irq <= 1'b0; pkt <= '0; pkt_n <= '0; rem <= '0; wleft <= '0;
      cur_lba <= '0; cur_w <= '0;
    end else begin
      if (irq_set) irq <= 1'b1;
      else if (rd_stat) irq <= 1'b0;
      case (st)
        S_IDLE: if (reg_wr) begin
          if (reg_addr == 3'd1) feat0 <= reg_wdata[0];
          if (reg_addr == 3'd4) bcnt[7:0] <= reg_wdata[7:0];
          if (reg_addr == 3'd5) bcnt[15:8] <= reg_wdata[7:0];
          if (is_pkt) begin
            abrt <= feat0;
            if (!feat0) begin
              st <= S_ACC; lim <= bcnt; pkt_n <= '0;
            end
          end
        end
        S_ACC: st <= S_PKT;
        S_PKT: if (wr_dat) begin
          pkt <= {pkt[79:0], reg_wdata[7:0], reg_wdata[15:8]};
          pkt_n <= pkt_n + 3'd1;
          if (pkt_n == 3'd5) st <= S_DEC;
        end
        S_DEC: begin
          cur_lba <= c_lba; cur_w <= '0;
          rem <= REM_W'(c_cnt) << BLK_SHIFT;
          if (c_bad) begin abrt <= 1'b1; st <= S_IDLE; end
          else if (c_cnt == 16'd0) st <= S_IDLE;
          else st <= S_GAP;
        end
        S_GAP: begin
          bcnt <= burst; wleft <= burst[15:1]; st <= S_XFER;
        end
        S_XFER: if (rd_dat) begin
          rem <= rem - REM_W'(2);
          wleft <= wleft - 15'd1;
          cur_w <= cur_w + 10'd1;
          if (cur_w == 10'h3FF) cur_lba <= cur_lba + 32'd1;
          if (last_word) st <= fin_word ? S_IDLE : S_GAP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_irq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !irq_set) |=> !irq);
  p_burst_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |=> (bcnt <= lim_eff && {wleft, 1'b0} == bcnt && bcnt != 16'd0));
  p_gap_after_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_word && !fin_word) |=> (bsy && !drq));
  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_word |=> (irq && st == S_IDLE && !abrt));
  p_dma_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pkt && feat0) |=> (abrt && irq && !drq));
endmodule

// File: tb/atapi_pio_ctrl_tb_top.sv
module atapi_pio_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata, blk_data;
  logic irq;
  logic [31:0] blk_lba;
  logic [9:0] blk_word;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] mdl(int lba, int w);
    return {lba[5:0], w[9:0]} ^ 16'hA5C3;
  endfunction
  assign blk_data = mdl(blk_lba, blk_word);

  atapi_pio_ctrl dut_i (.clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata,
    .reg_rdata, .irq, .blk_lba, .blk_word, .blk_data);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [15:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_irq(output bit got);
    got = 0;
    for (int i = 0; i < 100; i++) begin
      if (irq) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic issue(int lim, bit feat);
    wr(3'd4, 16'(lim & 255)); wr(3'd5, 16'((lim >> 8) & 255));
    wr(3'd1, {15'd0, feat}); wr(3'd7, 16'h00A0);
  endtask

  task automatic send_pkt(logic [7:0] op, int lba, int cnt);
    logic [7:0] b [12];
    logic [15:0] d;
    for (int i = 0; i < 12; i++) b[i] = 8'h0;
    b[0] = op; b[2] = 8'(lba >> 24); b[3] = 8'(lba >> 16); b[4] = 8'(lba >> 8);
    b[5] = 8'(lba); b[7] = 8'(cnt >> 8); b[8] = 8'(cnt);
    for (int i = 0; i < 10; i++) begin
      peek(3'd7, d); if (!d[7]) break; @(negedge clk);
    end
    chk("R2 packet request status", d, 16'h48);
    for (int i = 0; i < 6; i++) wr(3'd0, {b[2*i+1], b[2*i]});
  endtask

  task automatic t_read(int lba, int cnt, int lim);
    int rem, b, lim_e, pl, pw, bad;
    bit got;
    logic [15:0] d, lo, hi;
    issue(lim, 1'b0);
    send_pkt(8'h28, lba, cnt);
    rem = cnt * 2048; pl = lba; pw = 0;
    while (rem > 0) begin
      wait_irq(got);
      chk("R5 irq before burst", got, 1);
      rd(3'd7, d); chk("R5 status during burst", d, 16'h48);
      chk("R5 irq cleared by status read", irq, 0);
      lim_e = (lim < 2) ? 65534 : lim;
      b = (rem < lim_e) ? rem : (lim_e & ~1);
      rd(3'd4, lo); rd(3'd5, hi);
      chk((lim < 2) ? "R11 burst size" : "R4 burst size", {hi[7:0], lo[7:0]}, b);
      bad = 0;
      for (int i = 0; i < b / 2; i++) begin
        rd(3'd0, d);
        if (d !== mdl(pl, pw)) bad++;
        pw++; if (pw == 1024) begin pw = 0; pl++; end
      end
      chk("R3 data words mismatched", bad, 0);
      rem -= b;
      if (rem > 0) begin
        peek(3'd7, d); chk("R6 status between bursts", d, 16'hC0);
      end else begin
        chk("R7 completion irq", irq, 1);
        peek(3'd7, d); chk("R7 final status", d, 16'h40);
        rd(3'd7, d);
      end
    end
  endtask

  task automatic t_error(logic [7:0] op, int lba, int cnt, string tag);
    bit got;
    logic [15:0] d;
    issue(5120, 1'b0);
    send_pkt(op, lba, cnt);
    wait_irq(got); chk({tag, " irq"}, got, 1);
    peek(3'd7, d); chk({tag, " status"}, d, 16'h41);
    peek(3'd1, d); chk({tag, " error reg"}, d, 16'h04);
    rd(3'd7, d);
  endtask

  task automatic t_dma_sel;
    logic [15:0] d;
    issue(5120, 1'b1);
    chk("R8 irq", irq, 1);
    peek(3'd7, d); chk("R8 status", d, 16'h41);
    peek(3'd1, d); chk("R8 error reg", d, 16'h04);
    rd(3'd7, d);
    wr(3'd1, 16'h0);
  endtask

  task automatic t_zero;
    bit got;
    logic [15:0] d;
    issue(5120, 1'b0);
    send_pkt(8'h28, 3, 0);
    wait_irq(got); chk("R10 irq", got, 1);
    peek(3'd7, d); chk("R10 status", d, 16'h40);
    peek(3'd1, d); chk("R10 error reg", d, 16'h0);
    rd(3'd7, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(3'd7, d); chk("R1 reset status", d, 16'h40);
    peek(3'd1, d); chk("R1 reset error", d, 16'h0);
    chk("R1 reset irq", irq, 0);
    t_read(5, 1, 5120);
    t_read(62, 2, 1001);
    t_read(0, 3, 5121);
    t_read(7, 1, 2049);
    t_dma_sel();
    t_read(9, 1, 0);
    t_error(8'h28, 63, 2, "R9 range");
    t_read(1, 1, 1);
    t_error(8'h12, 0, 1, "R9 opcode");
    t_zero();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule